// File: doc/BRIEF.md
# Paper Tape Reader Controller

This controller sits between a processor's I/O port and a character-at-a-time tape reader. The processor sees two registers, picked by a select line. The first is a data register that returns the most recently read tape character. The second is a director register. Writing it issues commands, and reading it returns a status word. The reader side has four parts: a request output, a byte input with a valid strobe, a tape-loaded level and an end-of-tape level. The tape mechanics lie outside the block.

Motion is started and stopped by director commands. While tape is moving, every character fetch is delayed by a programmable number of clock cycles, `READ_DELAY`, which models the mechanical read time. Fetches pace themselves: a new character is requested only after the processor reads the data register, so the reader never runs ahead of software. A returned byte is presented in the low half of the 16-bit data word. The high half is passed through from the accumulator value on the bus. Running off the end of the tape raises alarm and motion-failure status together.

Top module: `tape_rdr_ctrl`

## Requirements
- R1: After reset, `irq` and `rdr_req` are low. A status read with no tape loaded shows only the protected (bit 7) and existence (bit 8) bits, as set by their parameters.
- R2: Status bit 10 (power) follows `tape_loaded`. Status bit 0 (ready) is `tape_loaded` and not motion failure.
- R3: Director write bits are decoded as follows. Bit 0 clears the controller. Bit 1 clears interrupts. Bit 2 enables the data interrupt. Bit 4 enables the alarm interrupt. Bit 5 starts motion, which sets busy (status bit 1) and schedules a fetch. Bit 6 stops motion, which clears busy and cancels any fetch. If bits 5 and 6 are both set, the stop wins.
- R4: `rdr_req` rises exactly `READ_DELAY` clock edges after the edge that scheduled the fetch. It stays high until `rdr_valid` or `tape_end` is seen, and it drops on the next edge.
- R5: A byte accepted while status bit 3 (data) is clear is stored, and it sets data. If the data interrupt is enabled, it also sets status bit 2 (interrupt) and `irq`.
- R6: A data register read returns `{cpu_acc[15:8], stored byte}` on `cpu_rdata` one cycle later. It clears data and interrupt. It schedules the next fetch only while busy.
- R7: A write to the data register pulses `cpu_rej` for one cycle and changes no status, byte or motion state.
- R8: A byte that arrives while data is still set is dropped. It sets status bit 6 (lost data) and bit 5 (alarm), and it raises the interrupt if the alarm interrupt is enabled.
- R9: `tape_end` during a request sets alarm and status bit 9 (motion failure), which clears ready. It raises `irq` only when the alarm interrupt is enabled.
- R10: Clear interrupts drops both enables, interrupt, alarm and lost data. Enable bits in the same write are applied after that clearing.
- R11: Clear controller stops motion and cancels any fetch. It clears busy, both enables, interrupt, data, alarm, lost data and motion failure, and it overrides every other bit of the same write.
- R12: A director read returns the status word on `cpu_rdata` one cycle later, with the bit layout given in R1 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | 0 selects the data register, 1 selects the director register |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | 16 | Write data (director command) |
| cpu_acc | input | 16 | Accumulator value; its high byte passes through on data reads |
| cpu_rdata | output | 16 | Registered read data |
| cpu_rej | output | 1 | One-cycle pulse for a rejected data register write |
| irq | output | 1 | Interrupt request (status interrupt bit) |
| rdr_req | output | 1 | Request a character from the reader |
| rdr_byte | input | 8 | Character from the reader |
| rdr_valid | input | 1 | `rdr_byte` is valid this cycle |
| tape_loaded | input | 1 | Tape present in the reader |
| tape_end | input | 1 | Tape has run out |

## Verification
A wrong fetch state shows up on `rdr_req`. If the counter or state is stuck, the request comes one or more cycles early or late, or never comes at all. A leaked request after stop or clear shows up within `READ_DELAY` cycles. A corrupted enable or pending flag shows up on `irq` on the first character or end-of-tape event after the corruption. A wrongly kept or dropped byte shows up on the next data read, one cycle after the read strobe. A status bit that is wrong in any way is seen on the next director read.

// File: rtl/trc_pkg.sv
package trc_pkg;
  // director command bit positions
  localparam int unsigned DIR_CLR_CTRL = 0;
  localparam int unsigned DIR_CLR_INT  = 1;
  localparam int unsigned DIR_DATA_EN  = 2;
  localparam int unsigned DIR_SPARE    = 3;
  localparam int unsigned DIR_ALARM_EN = 4;
  localparam int unsigned DIR_START    = 5;
  localparam int unsigned DIR_STOP     = 6;
  localparam int unsigned DIR_TOP_USED = DIR_STOP;

  // status word bit positions
  localparam int unsigned ST_READY = 0;
  localparam int unsigned ST_BUSY  = 1;
  localparam int unsigned ST_INT   = 2;
  localparam int unsigned ST_DATA  = 3;
  localparam int unsigned ST_ALARM = 5;
  localparam int unsigned ST_LOST  = 6;
  localparam int unsigned ST_PROT  = 7;
  localparam int unsigned ST_EXIST = 8;
  localparam int unsigned ST_MFAIL = 9;
  localparam int unsigned ST_POWER = 10;

  typedef enum logic [1:0] {FT_IDLE, FT_WAIT, FT_REQ} fetch_st_e;

  typedef struct packed {
    logic clr_ctrl;
    logic clr_int;
    logic data_en;
    logic alarm_en;
    logic start;
    logic stop;
  } dir_cmd_t;
endpackage

// File: rtl/trc_dir_decode.sv
module trc_dir_decode
  import trc_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] wdata,
  output dir_cmd_t          cmd
);
  logic unused_dir_bits;

  assign cmd.clr_ctrl = wdata[DIR_CLR_CTRL];
  assign cmd.clr_int  = wdata[DIR_CLR_INT];
  assign cmd.data_en  = wdata[DIR_DATA_EN];
  assign cmd.alarm_en = wdata[DIR_ALARM_EN];
  assign cmd.start    = wdata[DIR_START];
  assign cmd.stop     = wdata[DIR_STOP];

  assign unused_dir_bits = ^{wdata[DATA_W-1:DIR_TOP_USED+1], wdata[DIR_SPARE]};
endmodule

// File: rtl/trc_fetch.sv
module trc_fetch
  import trc_pkg::*;
#(
  parameter int unsigned DELAY = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic sched,
  input  logic cancel,
  input  logic rdr_valid,
  input  logic tape_end,
  output logic req,
  output logic done,
  output logic eot
);
  fetch_st_e st_q;
  logic      cnt_zero;

  generate
    if (DELAY > 1) begin : g_cnt
      localparam int unsigned CW = $clog2(DELAY);
      localparam logic [CW-1:0] LOAD = CW'(DELAY - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst)                             cnt_q <= '0;
        else if (sched)                      cnt_q <= LOAD;
        else if (st_q == FT_WAIT && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
      assign cnt_zero = (cnt_q == '0);
    end else begin : g_nocnt
      assign cnt_zero = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         st_q <= FT_IDLE;
    else if (cancel) st_q <= FT_IDLE;
    else if (sched)  st_q <= FT_WAIT;
    else begin
      case (st_q)
        FT_WAIT: if (cnt_zero) st_q <= FT_REQ;
        FT_REQ:  if (rdr_valid || tape_end) st_q <= FT_IDLE;
        default: st_q <= st_q;
      endcase
    end
  end

  assign req  = (st_q == FT_REQ);
  assign done = req & rdr_valid & ~cancel;
  assign eot  = req & tape_end & ~rdr_valid & ~cancel;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req && !rdr_valid && !tape_end && !cancel && !sched) |=> req) else $error("req dropped"); // R4
  AST_REQ_NEEDS_WAIT: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> $past(st_q == FT_WAIT)) else $error("req without wait"); // R4
endmodule

// File: rtl/trc_status.sv
module trc_status
  import trc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  dir_cmd_t cmd,
  input  logic     cmd_vld,
  input  logic     data_rd,
  input  logic     done,
  input  logic     eot,
  output logic     busy_q,
  output logic     int_q,
  output logic     data_q,
  output logic     alarm_q,
  output logic     lost_q,
  output logic     mfail_q
);
  logic den_q, aen_q, full;

  assign full = data_q & ~data_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; int_q <= 1'b0; data_q <= 1'b0; alarm_q <= 1'b0;
      lost_q <= 1'b0; mfail_q <= 1'b0; den_q <= 1'b0; aen_q <= 1'b0;
    end else begin
      if (cmd_vld && cmd.clr_int) begin
        den_q <= 1'b0; aen_q <= 1'b0; int_q <= 1'b0;
        alarm_q <= 1'b0; lost_q <= 1'b0;
      end
      if (cmd_vld && cmd.data_en)  den_q  <= 1'b1;
      if (cmd_vld && cmd.alarm_en) aen_q  <= 1'b1;
      if (cmd_vld && cmd.start)    busy_q <= 1'b1;
      if (cmd_vld && cmd.stop)     busy_q <= 1'b0;
      if (data_rd) begin
        data_q <= 1'b0;
        int_q  <= 1'b0;
      end
      if (done) begin
        if (full) begin
          lost_q  <= 1'b1;
          alarm_q <= 1'b1;
          if (aen_q) int_q <= 1'b1;
        end else begin
          data_q <= 1'b1;
          if (den_q) int_q <= 1'b1;
        end
      end
      if (eot) begin
        alarm_q <= 1'b1;
        mfail_q <= 1'b1;
        if (aen_q) int_q <= 1'b1;
      end
      if (cmd_vld && cmd.clr_ctrl) begin
        busy_q <= 1'b0; int_q <= 1'b0; data_q <= 1'b0; alarm_q <= 1'b0;
        lost_q <= 1'b0; mfail_q <= 1'b0; den_q <= 1'b0; aen_q <= 1'b0;
      end
    end
  end

  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (rst)
    $rose(int_q) |-> $past(den_q | aen_q)) else $error("irq without enable"); // R5
  AST_MFAIL_FROM_EOT: assert property (@(posedge clk) disable iff (rst)
    $rose(mfail_q) |-> $past(eot)) else $error("mfail without eot"); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !done) |=> !data_q && !int_q) else $error("read left data"); // R6
  AST_CLR_CTRL_ALL: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd.clr_ctrl) |=> !busy_q && !int_q && !mfail_q && !den_q && !aen_q) else $error("clear ctrl"); // R11
endmodule

// File: rtl/tape_rdr_ctrl.sv
module tape_rdr_ctrl
  import trc_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CHAR_W     = 8,
  parameter int unsigned READ_DELAY = 1000,
  parameter bit          PROTECTED  = 1'b0,
  parameter bit          EXISTS     = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W-1:0] cpu_acc,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rej,
  output logic              irq,
  output logic              rdr_req,
  input  logic [CHAR_W-1:0] rdr_byte,
  input  logic              rdr_valid,
  input  logic              tape_loaded,
  input  logic              tape_end
);
  dir_cmd_t          cmd;
  logic              cmd_vld, data_rd, sched, cancel, done, eot;
  logic              st_busy, st_int, st_data, st_alarm, st_lost, st_mfail;
  logic [CHAR_W-1:0] char_q;
  logic [DATA_W-1:0] status_w;
  logic              unused_acc_low;

  assign cmd_vld = cpu_wr & cpu_sel;
  assign data_rd = cpu_rd & ~cpu_sel;
  assign cancel  = cmd_vld & (cmd.stop | cmd.clr_ctrl);
  assign sched   = (cmd_vld & cmd.start) | (data_rd & st_busy);

  trc_dir_decode #(.DATA_W(DATA_W)) u_dec (
    .wdata (cpu_wdata),
    .cmd   (cmd)
  );

  trc_fetch #(.DELAY(READ_DELAY)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .sched     (sched),
    .cancel    (cancel),
    .rdr_valid (rdr_valid),
    .tape_end  (tape_end),
    .req       (rdr_req),
    .done      (done),
    .eot       (eot)
  );

  trc_status u_status (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .cmd_vld (cmd_vld),
    .data_rd (data_rd),
    .done    (done),
    .eot     (eot),
    .busy_q  (st_busy),
    .int_q   (st_int),
    .data_q  (st_data),
    .alarm_q (st_alarm),
    .lost_q  (st_lost),
    .mfail_q (st_mfail)
  );

  always_ff @(posedge clk) begin
    if (rst) char_q <= '0;
    else if (done && (!st_data || data_rd)) char_q <= rdr_byte;
  end

  always_comb begin
    status_w           = '0;
    status_w[ST_READY] = tape_loaded & ~st_mfail;
    status_w[ST_BUSY]  = st_busy;
    status_w[ST_INT]   = st_int;
    status_w[ST_DATA]  = st_data;
    status_w[ST_ALARM] = st_alarm;
    status_w[ST_LOST]  = st_lost;
    status_w[ST_PROT]  = PROTECTED;
    status_w[ST_EXIST] = EXISTS;
    status_w[ST_MFAIL] = st_mfail;
    status_w[ST_POWER] = tape_loaded;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
      cpu_rej   <= 1'b0;
    end else begin
      cpu_rej <= cpu_wr & ~cpu_sel;
      if (cpu_rd) cpu_rdata <= cpu_sel ? status_w : {cpu_acc[DATA_W-1:CHAR_W], char_q};
    end
  end

  assign irq            = st_int;
  assign unused_acc_low = ^cpu_acc[CHAR_W-1:0];

  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    rdr_req |-> st_busy) else $error("request while stopped"); // R3
  AST_REJ_DATA_WRITE: assert property (@(posedge clk) disable iff (rst)
    cpu_rej |-> $past(cpu_wr && !cpu_sel)) else $error("spurious reject"); // R7
  AST_REJ_KEEPS_BYTE: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !cpu_sel && !done) |=> $stable(char_q)) else $error("reject changed byte"); // R7
endmodule

// File: tb/tape_rdr_ctrl_tb.sv
module tape_rdr_ctrl_tb;
  localparam int unsigned D = 6;
  localparam int TAPE_N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        cpu_sel, cpu_wr, cpu_rd, cpu_rej, irq, rdr_req, tape_loaded, rewind;
  logic [15:0] cpu_wdata, cpu_acc, cpu_rdata;
  logic [7:0]  rdr_byte = 8'h00;
  logic        rdr_valid = 1'b0;
  logic        tape_end;
  int          idx = 0;
  int          checks = 0;
  int          errors = 0;
  int          seen = 0;
  bit          finished = 1'b0;
  logic        rd_d;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  tape_rdr_ctrl #(.READ_DELAY(D), .PROTECTED(1'b1), .EXISTS(1'b1)) u_dut (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_acc(cpu_acc), .cpu_rdata(cpu_rdata), .cpu_rej(cpu_rej),
    .irq(irq), .rdr_req(rdr_req), .rdr_byte(rdr_byte), .rdr_valid(rdr_valid),
    .tape_loaded(tape_loaded), .tape_end(tape_end)
  );

  function automatic logic [7:0] tbyte(int i);
    return 8'(8'h30 + i * 7);
  endfunction

  // tape model: answers each request with the next byte, then holds tape_end
  assign tape_end = (idx >= TAPE_N);
  always @(negedge clk) begin
    if (rewind) idx = 0;
    if (rdr_req && !rdr_valid && idx < TAPE_N) begin
      rdr_byte  <= tbyte(idx);
      rdr_valid <= 1'b1;
      idx = idx + 1;
    end else begin
      rdr_valid <= 1'b0;
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_d <= cpu_rd;
  always @(negedge clk) begin
    logic [15:0] e;
    string t;
    if (rd_d === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12 scoreboard empty actual=%h expected=none", cpu_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, cpu_rdata, e);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dir_wr(logic [15:0] v);
    @(negedge clk); cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_wdata = v;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic rd(logic sel, logic [15:0] acc, logic [15:0] exp, string tag);
    @(negedge clk); cpu_sel = sel; cpu_rd = 1'b1; cpu_acc = acc;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  initial begin
    cpu_sel = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_wdata = '0; cpu_acc = '0;
    tape_loaded = 1'b0; rewind = 1'b0;
    idle(3); rst = 1'b0; idle(1);
    chk("R1 irq after reset", {15'd0, irq}, 16'd0);
    chk("R1 req after reset", {15'd0, rdr_req}, 16'd0);
    rd(1'b1, 16'h0, 16'h0180, "R1 status no tape");
    tape_loaded = 1'b1; idle(1);
    rd(1'b1, 16'h0, 16'h0581, "R2 tape loaded");

    // R7: data write rejected
    @(negedge clk); cpu_sel = 1'b0; cpu_wr = 1'b1; cpu_wdata = 16'h00FF;
    @(negedge clk); cpu_wr = 1'b0;
    chk("R7 reject pulse", {15'd0, cpu_rej}, 16'd1);
    idle(1);
    chk("R7 reject one cycle", {15'd0, cpu_rej}, 16'd0);
    rd(1'b1, 16'h0, 16'h0581, "R7 status unchanged");
    rd(1'b0, 16'h1200, 16'h1200, "R7 byte unchanged");

    // R4 / R5: start with data interrupt enabled
    dir_wr(16'h0024);
    idle(D - 1);
    chk("R4 no early request", {15'd0, rdr_req}, 16'd0);
    idle(1);
    chk("R4 request on time", {15'd0, rdr_req}, 16'd1);
    idle(1);
    chk("R5 data irq", {15'd0, irq}, 16'd1);
    chk("R4 request drops", {15'd0, rdr_req}, 16'd0);
    rd(1'b1, 16'h0, 16'h058F, "R5 R12 status with data");
    rd(1'b0, 16'hA5FF, {8'hA5, tbyte(0)}, "R6 first byte");
    chk("R6 irq cleared by read", {15'd0, irq}, 16'd0);
    rd(1'b1, 16'h0, 16'h0583, "R6 status after read");
    idle(2 * D);
    rd(1'b0, 16'h3C00, {8'h3C, tbyte(1)}, "R6 second byte");

    // R3: stop, and no fetch while stopped
    dir_wr(16'h0040);
    rd(1'b1, 16'h0, 16'h0581, "R3 stop clears busy");
    rd(1'b0, 16'h7700, {8'h77, tbyte(1)}, "R6 stopped read");
    seen = 0;
    repeat (3 * D) begin
      @(negedge clk);
      if (rdr_req) seen++;
    end
    chk("R6 no fetch while stopped", 16'(seen), 16'd0);

    // R8: byte arrives while data still set
    dir_wr(16'h0020); idle(D + 3);
    rd(1'b1, 16'h0, 16'h058F, "R5 third byte");
    dir_wr(16'h0020); idle(D + 3);
    rd(1'b1, 16'h0, 16'h05EF, "R8 lost and alarm");
    rd(1'b0, 16'h0100, {8'h01, tbyte(2)}, "R8 first byte kept");
    dir_wr(16'h0002);
    chk("R10 clear interrupts", {15'd0, irq}, 16'd0);

    // R9: end of tape, alarm interrupt disabled
    idle(D + 3);
    rd(1'b1, 16'h0, 16'h07A2, "R9 end of tape status");
    chk("R9 no irq when masked", {15'd0, irq}, 16'd0);

    // R11 then R9 with alarm interrupt enabled
    dir_wr(16'h0001);
    rd(1'b1, 16'h0, 16'h0581, "R11 clear controller");
    dir_wr(16'h0030); idle(D + 3);
    chk("R9 alarm irq", {15'd0, irq}, 16'd1);
    rd(1'b1, 16'h0, 16'h07A6, "R9 end of tape with irq");

    dir_wr(16'h0001);
    chk("R11 irq cleared", {15'd0, irq}, 16'd0);
    tape_loaded = 1'b0; idle(1);
    rd(1'b1, 16'h0, 16'h0180, "R2 tape removed");
    rewind = 1'b1; idle(1); rewind = 1'b0; tape_loaded = 1'b1;
    dir_wr(16'h0020); idle(D + 3);
    chk("R11 enables cleared", {15'd0, irq}, 16'd0);
    rd(1'b1, 16'h0, 16'h058B, "R11 data without interrupt");

    // R10: clear and enable in one write
    dir_wr(16'h0006);
    chk("R10 no spurious irq", {15'd0, irq}, 16'd0);
    rd(1'b0, 16'h5A00, {8'h5A, tbyte(0)}, "R10 byte after rewind");
    idle(D + 3);
    chk("R10 enable applied after clear", {15'd0, irq}, 16'd1);

    // R3: start and stop together
    dir_wr(16'h0060);
    rd(1'b1, 16'h0, 16'h058D, "R3 stop wins");
    idle(D + 2);
    chk("R3 no request after stop wins", {15'd0, rdr_req}, 16'd0);

    idle(2);
    chk("R12 scoreboard drained", 16'(exp_q.size()), 16'd0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule